// File: doc/BRIEF.md
# Pad Boundary Scan Interception Cell

This cell sits on one chip pad, between the functional logic ("core") and the pad driver/receiver. Each wire that exists for the pad (pad input toward the core, core output toward the pad, core output-enable toward the pad) runs through a pair of multiplexers. One multiplexer faces the pad and the other faces the core. In functional mode the pair is transparent, so core and pad are joined directly. In test mode the pad side is driven from, or sampled into, its own scan bits, and the core side is driven from, or sampled into, a different set of scan bits. Test equipment can therefore isolate a faulty pad from a faulty core.

The cell holds its own capture/shift stages and update latches. It is strobed by an external test controller through `capture_en`, `shift_en`, `update_en` and `test_mode`. Cells are daisy-chained through `scan_in`/`scan_out`. A parameter selects the pad kind: input-only, output-only, tristate output, or bidirectional. Only the wires that exist for that kind get scan bits.

Top module: `pad_scan_cell`

## Requirements
- R1: Absent wires take fixed values on the ports. The input kind drives `pad_o`=0 and `pad_oe`=0. The output kind drives `pad_oe`=1 and `core_i`=0. The tristate kind drives `core_i`=0. These values hold in both modes.
- R2: When `test_mode`=0, `pad_o` follows `core_o`, `pad_oe` follows `core_oe` and `core_i` follows `pad_i` in the same cycle, whatever the strobes do.
- R3: When `test_mode`=1, `pad_o`, `pad_oe` and `core_i` come from their own update latches, and `core_o`/`core_oe` have no effect on the pad.
- R4: On a clock with `capture_en`=1, three scan stages sample their wires: the pad-input stage samples `pad_i`, the core-output stage samples `core_o` and the core-enable stage samples `core_oe`. The three drive stages (core input, pad output, pad enable) reload the current contents of their own update latches.
- R5: On a clock with `shift_en`=1 and `capture_en`=0, the chain moves one place. `scan_in` enters the first present stage and `scan_out` shows the last present stage. The update latches do not change unless `update_en` is also 1.
- R6: On a clock with `update_en`=1, every update latch takes the value its scan stage held before that edge. This includes an edge at which a shift also happens.
- R7: Stage order from `scan_in` to `scan_out` is: pad input, core output, core enable, core input, pad output, pad enable. Stages the kind lacks are skipped, giving chain lengths of 2 (input), 2 (output), 4 (tristate) and 6 (bidirectional).
- R8: If `capture_en` and `shift_en` are both 1 on the same clock, the capture takes effect and the shift is dropped.
- R9: While `rst_n`=0, all scan stages and update latches are 0, so `scan_out`=0 and the test-mode outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| test_mode | input | 1 | 1 = intercept, 0 = transparent |
| capture_en | input | 1 | Capture strobe |
| shift_en | input | 1 | Shift strobe |
| update_en | input | 1 | Update strobe |
| scan_in | input | 1 | Serial chain input |
| scan_out | output | 1 | Serial chain output |
| core_o | input | 1 | Core output value |
| core_oe | input | 1 | Core output enable |
| core_i | output | 1 | Value delivered to the core input |
| pad_i | input | 1 | Value received at the pad |
| pad_o | output | 1 | Value driven to the pad |
| pad_oe | output | 1 | Enable driven to the pad |

## Verification
The bench targets four error classes:

- **Coincident strobes.** When capture and shift fire together, a cell that shifts instead of capturing loses the sampled pin values. When shift and update fire together, a cell that copies post-shift contents latches a value one bit off.
- **Transparency.** Functional-mode outputs must track their inputs while the chain is busy. A cell that leaks latch values into functional mode would corrupt normal traffic.
- **Chain order and length.** A 1 is walked through each pad kind and must emerge after exactly that kind's chain length. Captured values must come out in the stated order. A swapped or missing stage shows up as a bit at the wrong position.
- **Drive-stage capture.** Drive stages must read back their own latch on capture, not a pin.

// File: rtl/pscan_pkg.sv
package pscan_pkg;

    typedef enum logic [1:0] {
        PK_INPUT    = 2'd0,
        PK_OUTPUT   = 2'd1,
        PK_TRISTATE = 2'd2,
        PK_BIDIR    = 2'd3
    } pad_kind_e;

    // Canonical stage slots, in order from serial input to serial output
    localparam int NSLOT  = 6;
    localparam int SL_PI  = 0;
    localparam int SL_CO  = 1;
    localparam int SL_COE = 2;
    localparam int SL_CI  = 3;
    localparam int SL_PO  = 4;
    localparam int SL_POE = 5;

    typedef struct packed {
        logic [NSLOT-1:0] shf;
        logic [NSLOT-1:0] upd;
    } chain_state_t;

    function automatic logic kind_has_in(pad_kind_e k);
        return (k == PK_INPUT) || (k == PK_BIDIR);
    endfunction

    function automatic logic kind_has_out(pad_kind_e k);
        return (k != PK_INPUT);
    endfunction

    function automatic logic kind_has_oe(pad_kind_e k);
        return (k == PK_TRISTATE) || (k == PK_BIDIR);
    endfunction

    function automatic logic [NSLOT-1:0] kind_mask(pad_kind_e k);
        logic [NSLOT-1:0] m;
        m = '0;
        m[SL_PI]  = kind_has_in(k);
        m[SL_CI]  = kind_has_in(k);
        m[SL_CO]  = kind_has_out(k);
        m[SL_PO]  = kind_has_out(k);
        m[SL_COE] = kind_has_oe(k);
        m[SL_POE] = kind_has_oe(k);
        return m;
    endfunction

    function automatic int first_slot(logic [NSLOT-1:0] m);
        int f;
        f = 0;
        for (int k = NSLOT - 1; k >= 0; k--) begin
            if (m[k]) f = k;
        end
        return f;
    endfunction

endpackage

// File: rtl/psc_chain.sv
module psc_chain
    import pscan_pkg::*;
#(
    parameter logic [NSLOT-1:0] MASK = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture_en,
    input  logic             shift_en,
    input  logic             update_en,
    input  logic             scan_in,
    input  logic [NSLOT-1:0] cap_val,
    output logic             scan_out,
    output logic [NSLOT-1:0] shf_q,
    output logic [NSLOT-1:0] upd_q
);

    chain_state_t st_d, st_q;

    // Next-state: capture wins over shift; update copies pre-edge stages
    always_comb begin
        logic carry;
        st_d  = st_q;
        carry = scan_in;
        if (capture_en) begin
            st_d.shf = cap_val & MASK;
        end else if (shift_en) begin
            for (int k = 0; k < NSLOT; k++) begin
                if (MASK[k]) begin
                    st_d.shf[k] = carry;
                    carry       = st_q.shf[k];
                end
            end
        end
        if (update_en) begin
            st_d.upd = st_q.shf;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Serial output is the last present stage
    always_comb begin
        scan_out = 1'b0;
        for (int k = 0; k < NSLOT; k++) begin
            if (MASK[k]) scan_out = st_q.shf[k];
        end
    end

    assign shf_q = st_q.shf;
    assign upd_q = st_q.upd;

endmodule

// File: rtl/psc_wire_mux.sv
module psc_wire_mux (
    input  logic test_mode,
    input  logic func_val,
    input  logic scan_val,
    output logic wire_out
);

    always_comb begin
        wire_out = test_mode ? scan_val : func_val;
    end

endmodule

// File: rtl/pad_scan_cell.sv
module pad_scan_cell
    import pscan_pkg::*;
#(
    parameter pad_kind_e KIND = PK_BIDIR
) (
    input  logic clk,
    input  logic rst_n,
    input  logic test_mode,
    input  logic capture_en,
    input  logic shift_en,
    input  logic update_en,
    input  logic scan_in,
    output logic scan_out,
    input  logic core_o,
    input  logic core_oe,
    output logic core_i,
    input  logic pad_i,
    output logic pad_o,
    output logic pad_oe
);

    localparam logic             HAS_IN  = kind_has_in(KIND);
    localparam logic             HAS_OUT = kind_has_out(KIND);
    localparam logic             HAS_OE  = kind_has_oe(KIND);
    localparam logic [NSLOT-1:0] MASK    = kind_mask(KIND);

    logic [NSLOT-1:0] cap_val;
    logic [NSLOT-1:0] shf_q;
    logic [NSLOT-1:0] upd_q;

    // Observe stages sample wires; drive stages read back their latch
    always_comb begin
        cap_val         = '0;
        cap_val[SL_PI]  = pad_i;
        cap_val[SL_CO]  = core_o;
        cap_val[SL_COE] = core_oe;
        cap_val[SL_CI]  = upd_q[SL_CI];
        cap_val[SL_PO]  = upd_q[SL_PO];
        cap_val[SL_POE] = upd_q[SL_POE];
    end

    psc_chain #(.MASK(MASK)) u_chain (
        .clk        (clk),
        .rst_n      (rst_n),
        .capture_en (capture_en),
        .shift_en   (shift_en),
        .update_en  (update_en),
        .scan_in    (scan_in),
        .cap_val    (cap_val),
        .scan_out   (scan_out),
        .shf_q      (shf_q),
        .upd_q      (upd_q)
    );

    generate
        if (HAS_OUT) begin : g_out
            psc_wire_mux u_mux_o (
                .test_mode (test_mode),
                .func_val  (core_o),
                .scan_val  (upd_q[SL_PO]),
                .wire_out  (pad_o)
            );
        end else begin : g_no_out
            assign pad_o = 1'b0;
        end

        if (HAS_OE) begin : g_oe
            psc_wire_mux u_mux_oe (
                .test_mode (test_mode),
                .func_val  (core_oe),
                .scan_val  (upd_q[SL_POE]),
                .wire_out  (pad_oe)
            );
        end else begin : g_no_oe
            assign pad_oe = HAS_OUT;
        end

        if (HAS_IN) begin : g_in
            psc_wire_mux u_mux_i (
                .test_mode (test_mode),
                .func_val  (pad_i),
                .scan_val  (upd_q[SL_CI]),
                .wire_out  (core_i)
            );
        end else begin : g_no_in
            assign core_i = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/psc_checker.sv
module psc_checker
    import pscan_pkg::*;
#(
    parameter pad_kind_e KIND = PK_BIDIR
) (
    input logic             clk,
    input logic             rst_n,
    input logic             test_mode,
    input logic             capture_en,
    input logic             shift_en,
    input logic             update_en,
    input logic             scan_in,
    input logic             scan_out,
    input logic             core_o,
    input logic             core_oe,
    input logic             core_i,
    input logic             pad_i,
    input logic             pad_o,
    input logic             pad_oe,
    input logic [NSLOT-1:0] shf_q,
    input logic [NSLOT-1:0] upd_q
);

    localparam logic [NSLOT-1:0] MASK  = kind_mask(KIND);
    localparam int               FIRST = first_slot(MASK);

    generate
        if (kind_has_out(KIND)) begin : g_a_out
            a_r2_pad_o_follows_core: assert property (@(posedge clk) disable iff (!rst_n)
                !test_mode |-> (pad_o == core_o));
            // R3: in test mode the pad output only moves on an update
            a_r3_pad_o_held: assert property (@(posedge clk) disable iff (!rst_n)
                (test_mode && !update_en) |=> (!test_mode || $stable(pad_o)));
        end
        if (kind_has_oe(KIND)) begin : g_a_oe
            a_r2_pad_oe_follows_core: assert property (@(posedge clk) disable iff (!rst_n)
                !test_mode |-> (pad_oe == core_oe));
        end
        if (kind_has_in(KIND)) begin : g_a_in
            a_r2_core_i_follows_pad: assert property (@(posedge clk) disable iff (!rst_n)
                !test_mode |-> (core_i == pad_i));
            a_r4_capture_pad_in: assert property (@(posedge clk) disable iff (!rst_n)
                capture_en |=> (shf_q[SL_PI] == $past(pad_i)));
        end
        if (kind_has_out(KIND)) begin : g_a_cap_o
            a_r4_capture_core_o: assert property (@(posedge clk) disable iff (!rst_n)
                capture_en |=> (shf_q[SL_CO] == $past(core_o)));
        end
    endgenerate

    a_r5_shift_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && !capture_en) |=> (shf_q[FIRST] == $past(scan_in)));

    a_r5_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !update_en |=> $stable(upd_q));

    a_r6_update_copy: assert property (@(posedge clk) disable iff (!rst_n)
        update_en |=> (upd_q == $past(shf_q)));

    a_r8_capture_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (capture_en && shift_en) |=> (shf_q[SL_CO] == $past(core_o) || !MASK[SL_CO]));

    a_r9_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (shf_q == '0 && upd_q == '0 && scan_out == 1'b0));

endmodule

bind pad_scan_cell psc_checker #(.KIND(KIND)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .test_mode  (test_mode),
    .capture_en (capture_en),
    .shift_en   (shift_en),
    .update_en  (update_en),
    .scan_in    (scan_in),
    .scan_out   (scan_out),
    .core_o     (core_o),
    .core_oe    (core_oe),
    .core_i     (core_i),
    .pad_i      (pad_i),
    .pad_o      (pad_o),
    .pad_oe     (pad_oe),
    .shf_q      (shf_q),
    .upd_q      (upd_q)
);

// File: tb/sim_pad_scan_cell.sv
module sim_pad_scan_cell;
    import pscan_pkg::*;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n, tm, cap, shf, upd, sin, co, coe, pi;
    logic so0, ci0, po0, poe0;
    logic so_in, ci_in, po_in, poe_in;
    logic so_out, ci_out, po_out, poe_out;
    logic so_tri, ci_tri, po_tri, poe_tri;

    pad_scan_cell #(.KIND(PK_BIDIR)) u0 (
        .clk(clk), .rst_n(rst_n), .test_mode(tm), .capture_en(cap), .shift_en(shf),
        .update_en(upd), .scan_in(sin), .scan_out(so0), .core_o(co), .core_oe(coe),
        .core_i(ci0), .pad_i(pi), .pad_o(po0), .pad_oe(poe0));
    pad_scan_cell #(.KIND(PK_INPUT)) u_in (
        .clk(clk), .rst_n(rst_n), .test_mode(tm), .capture_en(cap), .shift_en(shf),
        .update_en(upd), .scan_in(sin), .scan_out(so_in), .core_o(co), .core_oe(coe),
        .core_i(ci_in), .pad_i(pi), .pad_o(po_in), .pad_oe(poe_in));
    pad_scan_cell #(.KIND(PK_OUTPUT)) u_out (
        .clk(clk), .rst_n(rst_n), .test_mode(tm), .capture_en(cap), .shift_en(shf),
        .update_en(upd), .scan_in(sin), .scan_out(so_out), .core_o(co), .core_oe(coe),
        .core_i(ci_out), .pad_i(pi), .pad_o(po_out), .pad_oe(poe_out));
    pad_scan_cell #(.KIND(PK_TRISTATE)) u_tri (
        .clk(clk), .rst_n(rst_n), .test_mode(tm), .capture_en(cap), .shift_en(shf),
        .update_en(upd), .scan_in(sin), .scan_out(so_tri), .core_o(co), .core_oe(coe),
        .core_i(ci_tri), .pad_i(pi), .pad_o(po_tri), .pad_oe(poe_tri));

    // Reference model of the bidirectional cell: slot 0 nearest scan_in
    logic [5:0] m_sr, m_up;
    int    nvec  = 0;
    int    nfail = 0;
    string tag   = "R9";

    task automatic chk(string what, logic act, logic exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
        end
    endtask

    function automatic logic exp_pad_o(logic t, logic c, logic [5:0] u);
        return t ? u[4] : c;
    endfunction
    function automatic logic exp_pad_oe(logic t, logic ce, logic [5:0] u);
        return t ? u[5] : ce;
    endfunction
    function automatic logic exp_core_i(logic t, logic p, logic [5:0] u);
        return t ? u[3] : p;
    endfunction

    task automatic check_u0();
        chk("pad_o",    po0,  exp_pad_o(tm, co, m_up));
        chk("pad_oe",   poe0, exp_pad_oe(tm, coe, m_up));
        chk("core_i",   ci0,  exp_core_i(tm, pi, m_up));
        chk("scan_out", so0,  m_sr[5]);
    endtask

    task automatic check_fixed();
        chk("R1 input-kind pad_o",  po_in,  1'b0);
        chk("R1 input-kind pad_oe", poe_in, 1'b0);
        chk("R1 output-kind pad_oe", poe_out, 1'b1);
        chk("R1 output-kind core_i", ci_out,  1'b0);
        chk("R1 tristate-kind core_i", ci_tri, 1'b0);
    endtask

    task automatic cycle(logic c, logic s, logic u, logic t, logic d,
                         logic o, logic oe, logic p);
        logic [5:0] nsr, nup;
        @(negedge clk);
        cap = c; shf = s; upd = u; tm = t; sin = d; co = o; coe = oe; pi = p;
        #1;
        check_u0();
        @(posedge clk);
        nsr = m_sr;
        nup = m_up;
        if (c)      nsr = {m_up[5], m_up[4], m_up[3], oe, o, p};
        else if (s) nsr = {m_sr[4:0], d};
        if (u)      nup = m_sr;
        m_sr = nsr;
        m_up = nup;
        #1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog (R1..R9 run): actual hung expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        void'($urandom(32'h1C0DE5));
        rst_n = 1'b0; tm = 1'b1; cap = 1'b0; shf = 1'b0; upd = 1'b0;
        sin = 1'b1; co = 1'b1; coe = 1'b1; pi = 1'b1;
        m_sr = '0; m_up = '0;
        repeat (3) @(posedge clk);
        #1;
        // R9: reset clears stages and latches
        tag = "R9";
        check_u0();
        @(negedge clk);
        rst_n = 1'b1;

        // R2: transparent while chain is busy
        tag = "R2";
        cycle(0,1,0,0,1, 1,0,1);
        cycle(0,1,1,0,0, 0,1,0);
        cycle(1,0,1,0,1, 1,1,0);
        cycle(0,1,0,0,1, 0,0,1);
        chk("R2 input-kind core_i", ci_in, pi);
        chk("R2 output-kind pad_o", po_out, co);

        // R5/R6: load pattern then update; latches hold during shift
        tag = "R5";
        for (int k = 0; k < 6; k++) cycle(0,1,0,1,k[0], 1,1,1);
        tag = "R6";
        cycle(0,0,1,1,0, 0,0,0);
        // R3: core changes do not reach pad in test mode
        tag = "R3";
        cycle(0,0,0,1,0, 1,1,0);
        cycle(0,0,0,1,0, 0,0,1);
        cycle(0,1,0,1,1, 1,0,1);
        check_fixed();

        // R4/R7: capture then shift all six out to check order
        tag = "R4";
        cycle(1,0,0,1,0, 0,1,1);
        tag = "R7";
        for (int k = 0; k < 6; k++) cycle(0,1,0,1,0, 1,0,0);

        // R8: capture+shift coincide; R6: shift+update coincide
        tag = "R8";
        cycle(1,1,0,1,1, 1,0,1);
        cycle(0,0,0,1,0, 0,0,0);
        tag = "R6";
        cycle(0,1,1,1,1, 0,0,0);
        cycle(0,0,0,1,0, 0,0,0);

        // R7: chain length per kind, walk a single 1 through
        tag = "R7";
        for (int k = 0; k < 8; k++) cycle(0,1,0,0,0, 0,0,0);
        cycle(0,1,0,0,1, 0,0,0);
        for (int k = 1; k <= 4; k++) begin
            chk("R7 input-kind length 2",    so_in,  (k == 2));
            chk("R7 output-kind length 2",   so_out, (k == 2));
            chk("R7 tristate-kind length 4", so_tri, (k == 4));
            cycle(0,1,0,0,0, 0,0,0);
        end

        // Random mix, all requirements via the model
        tag = "R2-R8 random";
        for (int n = 0; n < 3000; n++) begin
            cycle(($urandom % 6) == 0, ($urandom % 2) == 0, ($urandom % 5) == 0,
                  ($urandom % 4) != 0, 1'($urandom), 1'($urandom), 1'($urandom),
                  1'($urandom));
            if ((n % 50) == 0) check_fixed();
        end
        @(negedge clk);
        #1;
        check_u0();

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

endmodule